// File: doc/BRIEF.md
# Associative Page Translation Cache

This block keeps a handful of recent page translations close to the processor. A lookup presents a virtual page number, the in-page offset and the address-space identifier of the running process. All stored entries are compared with that page number and identifier at once. One clock later the block answers. On a hit it returns the stored frame number and the physical address, which is the frame number placed above the unchanged offset. On a miss it raises a miss flag, and the surrounding logic then fetches the translation from the page table in memory.

The fetched translation is written back through the refill port. A refill goes to the entry that already holds the same page and identifier if there is one. Otherwise it goes to the lowest free entry. When every entry is occupied, a rotating pointer picks the entry to replace. Entries that belong to different address spaces can sit side by side, so a context switch does not need a flush. The flush input empties the whole cache in a single cycle.

The response is held in a small state machine with three named states. `RS_IDLE` means no answer this cycle. `RS_HIT` means a translation was found. `RS_MISS` means the page table must be consulted. On every clock edge the next state is chosen from the lookup presented in that cycle:
- `RS_IDLE` is taken when no lookup is requested.
- `RS_MISS` is taken on a lookup that finds no entry, or that coincides with a flush.
- `RS_HIT` is taken on a lookup that matches a valid entry.

Any of the three states can move to any other.

Top module: `assoc_tlb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsp_valid` is 0. No entry is valid after reset, so the first lookup misses.
- R2: A lookup presented in cycle N produces `rsp_valid`=1 in cycle N+1, exactly one cycle later. A cycle with no lookup produces `rsp_valid`=0 in the next cycle.
- R3: A lookup hits only if a valid entry holds both the same page number and the same identifier. On a hit, `rsp_hit`=1, `rsp_miss`=0, and `rsp_pfn` equals the stored frame number.
- R4: On a hit, `rsp_paddr` is {frame number, offset}, with the offset in the low OFF_W bits unchanged. On a miss, `rsp_miss`=1, `rsp_hit`=0, and both `rsp_pfn` and `rsp_paddr` are 0.
- R5: The same page number under different identifiers occupies separate entries. Each identifier hits only its own frame number. An identifier that has no entry for that page misses.
- R6: A refill whose page and identifier are not already stored is written to the lowest-numbered invalid entry, without disturbing the other entries.
- R7: When all entries are valid, a new refill replaces the entry selected by a rotating pointer. The pointer starts at entry 0 after reset, advances by one on each such replacement, and wraps from ENTRIES-1 back to 0.
- R8: A refill whose page and identifier match a valid entry overwrites that entry's frame number. It does not advance the rotating pointer and does not create a second entry.
- R9: A lookup presented in the same cycle as a refill of the same page reports a miss. The refilled translation hits from the next cycle on.
- R10: Flush invalidates every entry in one cycle. A lookup presented in the same cycle as the flush misses, and a refill presented in the same cycle as the flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Offset within the page |
| lk_asid | input | ASID_W | Identifier of the requesting address space |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Page number of the new translation |
| rf_asid | input | ASID_W | Identifier of the new translation |
| rf_pfn | input | PFN_W | Frame number of the new translation |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Page-table lookup required |
| rsp_pfn | output | PFN_W | Frame number on a hit, else 0 |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit, else 0 |

## Verification
The bench builds the block with four entries, a 6-bit page number, a 2-bit identifier, a 5-bit frame number and a 4-bit offset. With only four entries, a few refills are enough to fill the cache, so replacement and pointer wraparound (R7) occur often. The narrow page and identifier fields make random traffic repeat the same page under several identifiers (R5), refill pages that are already stored (R8), and collide lookups with refills in the same cycle (R9).

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              valid_o,
    output logic              lk_match_o,
    output logic              rf_match_o,
    output logic [PFN_W-1:0]  pfn_o
);
    logic              valid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid_q <= 1'b0;
        end else if (wr) begin
            valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            asid_q <= '0;
            pfn_q  <= '0;
        end else if (wr && !clr) begin
            vpn_q  <= wr_vpn;
            asid_q <= wr_asid;
            pfn_q  <= wr_pfn;
        end
    end

    assign valid_o    = valid_q;
    assign lk_match_o = valid_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
    assign rf_match_o = valid_q && (vpn_q == wr_vpn) && (asid_q == wr_asid);
    assign pfn_o      = pfn_q;

    // R6: a write without a clear leaves the entry valid
    p_write_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> valid_o);
    // R10: a clear empties the entry on the next edge
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid_o);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    output logic [ENTRIES-1:0] sel
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0] rr_q;
    logic             any_dup;
    logic             all_full;
    logic             found;

    assign any_dup  = |dup_vec;
    assign all_full = &valid_vec;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        if (any_dup) begin
            sel = dup_vec;
        end else if (!all_full) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!found && !valid_vec[i]) begin
                    sel[i] = 1'b1;
                    found  = 1'b1;
                end
            end
        end else begin
            sel[rr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (alloc && all_full && !any_dup) begin
            if (rr_q == PTR_W'(ENTRIES - 1)) rr_q <= '0;
            else                             rr_q <= rr_q + 1'b1;
        end
    end

    // R7: every replacement of a full cache moves the pointer
    p_rr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && all_full && !any_dup) |=> (rr_q != $past(rr_q)));
    // R8: overwriting an existing entry keeps the pointer
    p_rr_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && any_dup) |=> $stable(rr_q));
    // R6: at most one entry is chosen
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [OFF_W-1:0]       lk_off,
    input  logic [ASID_W-1:0]      lk_asid,
    input  logic                   rf_valid,
    input  logic [VPN_W-1:0]       rf_vpn,
    input  logic [ASID_W-1:0]      rf_asid,
    input  logic [PFN_W-1:0]       rf_pfn,
    input  logic                   flush,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic [PFN_W-1:0]       rsp_pfn,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr
);
    localparam int PA_W = PFN_W + OFF_W;

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match_vec;
    logic [ENTRIES-1:0] rf_match_vec;
    logic [ENTRIES-1:0] wr_sel;
    logic [ENTRIES-1:0] wr_vec;
    logic [PFN_W-1:0]   pfn_arr [ENTRIES];
    logic               rf_accept;
    logic               lk_hit;
    logic [PFN_W-1:0]   hit_pfn;

    rsp_state_e       state_q, state_d;
    logic [PFN_W-1:0] pfn_q;
    logic [OFF_W-1:0] off_q;

    assign rf_accept = rf_valid && !flush;
    assign wr_vec    = rf_accept ? wr_sel : '0;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_entry #(
            .VPN_W (VPN_W),
            .ASID_W(ASID_W),
            .PFN_W (PFN_W)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (flush),
            .wr        (wr_vec[g]),
            .wr_vpn    (rf_vpn),
            .wr_asid   (rf_asid),
            .wr_pfn    (rf_pfn),
            .lk_vpn    (lk_vpn),
            .lk_asid   (lk_asid),
            .valid_o   (valid_vec[g]),
            .lk_match_o(lk_match_vec[g]),
            .rf_match_o(rf_match_vec[g]),
            .pfn_o     (pfn_arr[g])
        );
    end

    tlb_victim #(
        .ENTRIES(ENTRIES)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (rf_accept),
        .valid_vec(valid_vec),
        .dup_vec  (rf_match_vec),
        .sel      (wr_sel)
    );

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match_vec[i]) hit_pfn = hit_pfn | pfn_arr[i];
        end
    end
    assign lk_hit = |lk_match_vec;

    always_comb begin
        if (!lk_valid)            state_d = RS_IDLE;
        else if (flush || !lk_hit) state_d = RS_MISS;
        else                       state_d = RS_HIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            pfn_q   <= '0;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            pfn_q   <= hit_pfn;
            off_q   <= lk_off;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_pfn   = '0;
        rsp_paddr = '0;
        unique case (state_q)
            RS_IDLE: begin
            end
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_pfn   = pfn_q;
                rsp_paddr = PA_W'({pfn_q, off_q});
            end
            RS_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R2: a lookup is answered one cycle later
    p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_quiet_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R4: the offset passes through unchanged on a hit
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_off)));
    // R8: no page and identifier pair is ever stored twice
    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match_vec));
    // R10: flush leaves no valid entry
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
    // R4: hit and miss never together
    p_hit_xor_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));
endmodule

// File: tb/tb_assoc_tlb.sv
module tb_assoc_tlb;
    localparam int ENTRIES = 4;
    localparam int VPN_W   = 6;
    localparam int OFF_W   = 4;
    localparam int PFN_W   = 5;
    localparam int ASID_W  = 2;
    localparam int PA_W    = PFN_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [OFF_W-1:0]  lk_off = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              rf_valid = 1'b0;
    logic [VPN_W-1:0]  rf_vpn = '0;
    logic [ASID_W-1:0] rf_asid = '0;
    logic [PFN_W-1:0]  rf_pfn = '0;
    logic              flush = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_miss;
    logic [PFN_W-1:0]  rsp_pfn;
    logic [PA_W-1:0]   rsp_paddr;

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the cache contents
    bit                m_v    [ENTRIES];
    logic [VPN_W-1:0]  m_vpn  [ENTRIES];
    logic [ASID_W-1:0] m_asid [ENTRIES];
    logic [PFN_W-1:0]  m_pfn  [ENTRIES];
    int                m_rr;

    always #2.5 clk = ~clk;

    assoc_tlb #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .OFF_W(OFF_W),
        .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_asid(lk_asid),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
        .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_pfn(rsp_pfn), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int find_entry(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
        for (int i = 0; i < ENTRIES; i++)
            if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
        return -1;
    endfunction

    function automatic int pick_slot(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
        int d;
        d = find_entry(v, a);
        if (d >= 0) return d;
        for (int i = 0; i < ENTRIES; i++) if (!m_v[i]) return i;
        return -2;
    endfunction

    task automatic step(input bit lk, input int v, input int o, input int a,
                        input bit rf, input int rv, input int ra, input int rp,
                        input bit fl, input string tag);
        bit e_valid, e_hit;
        int e_pfn, e_pa, idx, slot;
        @(negedge clk);
        lk_valid = lk; lk_vpn = VPN_W'(v); lk_off = OFF_W'(o); lk_asid = ASID_W'(a);
        rf_valid = rf; rf_vpn = VPN_W'(rv); rf_asid = ASID_W'(ra); rf_pfn = PFN_W'(rp);
        flush = fl;
        e_valid = lk; e_hit = 1'b0; e_pfn = 0; e_pa = 0;
        if (lk && !fl) begin
            idx = find_entry(VPN_W'(v), ASID_W'(a));
            if (idx >= 0) begin
                e_hit = 1'b1;
                e_pfn = int'(m_pfn[idx]);
                e_pa  = (e_pfn << OFF_W) | (o & ((1 << OFF_W) - 1));
            end
        end
        if (fl) begin
            for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
        end else if (rf) begin
            slot = pick_slot(VPN_W'(rv), ASID_W'(ra));
            if (slot == -2) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % ENTRIES;
            end
            m_v[slot] = 1'b1; m_vpn[slot] = VPN_W'(rv);
            m_asid[slot] = ASID_W'(ra); m_pfn[slot] = PFN_W'(rp);
        end
        @(posedge clk);
        #1;
        chk(tag, "rsp_valid", int'(rsp_valid), int'(e_valid));
        if (e_valid) begin
            chk(tag, "rsp_hit", int'(rsp_hit), int'(e_hit));
            chk(tag, "rsp_miss", int'(rsp_miss), int'(!e_hit));
            chk(tag, "rsp_pfn", int'(rsp_pfn), e_pfn);
            chk(tag, "rsp_paddr", int'(rsp_paddr), e_pa);
        end
    endtask

    task automatic look(input int v, input int o, input int a, input string tag);
        step(1'b1, v, o, a, 1'b0, 0, 0, 0, 1'b0, tag);
    endtask

    task automatic fill(input int v, input int a, input int p, input string tag);
        step(1'b0, 0, 0, 0, 1'b1, v, a, p, 1'b0, tag);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        for (int i = 0; i < ENTRIES; i++) begin
            m_v[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
        end
        m_rr = 0;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);

        // R1: empty after reset
        look(5, 3, 0, "R1");
        // R2: idle cycle gives no response
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b0, "R2");
        // R6: lowest free slots, then hits with offset kept (R3, R4)
        fill(10, 1, 7, "R6");
        fill(11, 1, 9, "R6");
        look(10, 15, 1, "R3");
        look(11, 4, 1, "R4");
        look(12, 4, 1, "R4");
        // R9: lookup with refill of the same page in one cycle misses
        step(1'b1, 20, 2, 1, 1'b1, 20, 1, 21, 1'b0, "R9");
        look(20, 2, 1, "R9");
        // R5: same page, other identifiers
        fill(10, 2, 30, "R5");
        look(10, 6, 2, "R5");
        look(10, 6, 1, "R5");
        look(10, 6, 3, "R5");
        // R7: cache full now; replacements rotate 0,1,2,3,0
        fill(40, 0, 1, "R7");
        fill(41, 0, 2, "R7");
        look(10, 0, 1, "R7");
        look(11, 0, 1, "R7");
        look(40, 1, 0, "R7");
        fill(42, 0, 3, "R7");
        fill(43, 0, 4, "R7");
        fill(44, 0, 5, "R7");
        look(40, 0, 0, "R7");
        look(44, 0, 0, "R7");
        // R8: overwrite in place, pointer kept
        fill(44, 0, 17, "R8");
        look(44, 8, 0, "R8");
        fill(45, 0, 6, "R8");
        look(41, 0, 0, "R8");
        look(42, 0, 0, "R8");
        // R10: flush with lookup and refill in the same cycle
        step(1'b1, 44, 1, 0, 1'b1, 50, 0, 9, 1'b1, "R10");
        look(50, 0, 0, "R10");
        look(45, 0, 0, "R10");
        fill(50, 0, 9, "R10");
        look(50, 3, 0, "R10");

        // random traffic over a small page and identifier space
        for (int n = 0; n < 4000; n++) begin
            bit lk, rf, fl;
            lk = ($urandom % 4) != 0;
            rf = ($urandom % 3) == 0;
            fl = ($urandom % 60) == 0;
            step(lk, int'($urandom % 8), int'($urandom % 16), int'($urandom % 4),
                 rf, int'($urandom % 8), int'($urandom % 4), int'($urandom % 32),
                 fl, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule